// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds an Ethernet transmit path from a ring of buffer descriptors kept in shared memory. After software fills one or more descriptors and issues a start strobe, the engine fetches each descriptor over a byte-wide memory port. It reads the buffer that the descriptor points to one byte at a time and streams those bytes out in order. It gathers consecutive buffers into one frame until a descriptor marked as the final buffer is reached.

A descriptor occupies eight bytes, most significant byte first:
- a 16-bit control word at byte offset 0;
- a 16-bit byte count at offsets 2..3;
- a 32-bit buffer address at offsets 4..7.

After a descriptor is used, the engine rewrites its control byte with the ready flag cleared, which hands the descriptor back to software. It then moves to the next slot, or returns to the ring base when the descriptor asks for it. Frames are held to a hard byte ceiling. Pulses report each consumed buffer, each completed frame, and each frame that hit the ceiling.

The memory port holds a request until it is acknowledged, so one access finishes per acknowledge. Frame bytes appear on `out_valid`/`out_data`. A single-cycle `out_eof` closes each frame, including a frame with no bytes.

Top module: `txd_ring_engine`

## Requirements
- R1: After reset, `mem_req`, `out_valid`, `out_eof`, `evt_txb`, `evt_txf` and `evt_babt` are all low.
- R2: The control word takes these flags: ready at bit 15, wrap at bit 13, final buffer at bit 11. A fetched descriptor whose ready bit is 0 stops the engine with the descriptor pointer left on that slot. The next accepted start refetches that same slot.
- R3: A start strobe has no effect while `cfg_en` is low. No memory request is issued and memory is left unchanged.
- R4: The buffer bytes at addresses address..address+count-1 are read in ascending order and presented on `out_data` with `out_valid`, one byte per pulse. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.
- R5: A descriptor with the final-buffer bit set ends the frame. After its bytes, `out_eof` and `evt_txf` pulse once, even for a count of 0. The frame byte count then restarts at 0.
- R6: A frame carries at most MAX_FRAME (2032) bytes. A descriptor that would pass the ceiling is cut to the bytes that remain, and `evt_babt` pulses once for it. A frame of exactly 2032 bytes does not pulse `evt_babt`.
- R7: Every consumed descriptor is written back at byte offset 0 with bit 7 of that byte (control bit 15) cleared and the other seven bits unchanged. `evt_txb` pulses once per consumed descriptor.
- R8: After a descriptor with the wrap bit set, the next fetch is at the ring base. Otherwise the next fetch is 8 bytes higher.
- R9: A write of the ring base forces its low 2 bits to 0 and moves the descriptor pointer to that base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Controller enable; gates the start strobe |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | AW | Ring base write value |
| start | input | 1 | Start strobe: walk ready descriptors |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 8 | Write data (descriptor control byte) |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_eof | output | 1 | End-of-frame pulse |
| evt_txb | output | 1 | Descriptor consumed pulse |
| evt_txf | output | 1 | Frame completed pulse |
| evt_babt | output | 1 | Frame hit the byte ceiling pulse |

## Verification
The bench targets a frame that reaches the 2032-byte ceiling in its second buffer and a frame that fills the ceiling exactly. A design with an off-by-one limit would either emit a 2033rd byte or raise the overflow pulse without cause. A zero-length final buffer must still close its frame; a design that counts down before testing would stall or skip `out_eof`. The bench checks that a wrapped descriptor returns to the base rather than touching the next slot, and that a stopped walk resumes on the same slot. It checks that a start with the enable low leaves memory untouched and that a misaligned base write still fetches from the aligned address.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
   localparam int DESC_BYTES = 8;
   localparam int BIT_READY  = 15;
   localparam int BIT_WRAP   = 13;
   localparam int BIT_FINAL  = 11;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_FETCH,
      WS_CHECK,
      WS_DATA,
      WS_WBACK
   } walk_state_e;
endpackage

// File: rtl/tdr_base_reg.sv
module tdr_base_reg #(
   parameter int AW    = 32,
   parameter int ALIGN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] wdata,
   output logic [AW-1:0] base_q,
   output logic [AW-1:0] base_nxt
);
   generate
      if (ALIGN == 0) begin : g_noalign
         assign base_nxt = wdata;
      end else begin : g_align
         assign base_nxt = {wdata[AW-1:ALIGN], {ALIGN{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)  base_q <= '0;
      else if (wr) base_q <= base_nxt;
   end
endmodule

// File: rtl/tdr_len_clip.sv
module tdr_len_clip #(
   parameter int LW        = 16,
   parameter int CW        = 11,
   parameter int MAX_FRAME = 2032
) (
   input  logic [CW-1:0] frame_cnt,
   input  logic [LW-1:0] req_len,
   output logic [LW-1:0] eff_len,
   output logic          clipped
);
   logic [31:0] room;

   always_comb begin
      room    = 32'(MAX_FRAME) - 32'(frame_cnt);
      clipped = 32'(req_len) > room;
      eff_len = clipped ? LW'(room) : req_len;
   end
endmodule

// File: rtl/tdr_walker.sv
module tdr_walker
   import tdr_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LW        = 16,
   parameter int CW        = 11,
   parameter int MAX_FRAME = 2032
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_en,
   input  logic          start,
   input  logic          base_wr,
   input  logic [AW-1:0] base_nxt,
   input  logic [AW-1:0] base_q,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic          mem_ack,
   input  logic [7:0]    mem_rdata,
   output logic          out_valid,
   output logic [7:0]    out_data,
   output logic          out_eof,
   output logic          evt_txb,
   output logic          evt_txf,
   output logic          evt_babt,
   output logic          walk_idle,
   output logic [CW-1:0] frame_cnt,
   output logic [AW-1:0] desc_ptr
);
   localparam int IW = $clog2(DESC_BYTES);

   walk_state_e                st_q;
   logic [IW-1:0]              idx_q;
   logic [DESC_BYTES*8-1:0]    desc_q;
   logic [AW-1:0]              ptr_q;
   logic [LW-1:0]              boff_q;
   logic [LW-1:0]              eff_q;
   logic [CW-1:0]              cnt_q;

   logic [15:0]                ctl_w;
   logic [LW-1:0]              len_w;
   logic [AW-1:0]              buf_w;
   logic [LW-1:0]              clip_len;
   logic                       clip_hit;

   assign ctl_w = desc_q[63:48];
   assign len_w = LW'(desc_q[47:32]);
   assign buf_w = AW'(desc_q[31:0]);

   tdr_len_clip #(.LW(LW), .CW(CW), .MAX_FRAME(MAX_FRAME)) u_clip (
      .frame_cnt (cnt_q),
      .req_len   (len_w),
      .eff_len   (clip_len),
      .clipped   (clip_hit)
   );

   always_comb begin
      mem_req   = (st_q == WS_FETCH) || (st_q == WS_DATA) || (st_q == WS_WBACK);
      mem_we    = (st_q == WS_WBACK);
      mem_wdata = {1'b0, ctl_w[14:8]};
      case (st_q)
         WS_FETCH: mem_addr = ptr_q + AW'(idx_q);
         WS_DATA:  mem_addr = buf_w + AW'(boff_q);
         WS_WBACK: mem_addr = ptr_q;
         default:  mem_addr = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= WS_IDLE;
         idx_q     <= '0;
         desc_q    <= '0;
         ptr_q     <= '0;
         boff_q    <= '0;
         eff_q     <= '0;
         cnt_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_eof   <= 1'b0;
         evt_txb   <= 1'b0;
         evt_txf   <= 1'b0;
         evt_babt  <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_eof   <= 1'b0;
         evt_txb   <= 1'b0;
         evt_txf   <= 1'b0;
         evt_babt  <= 1'b0;
         case (st_q)
            WS_IDLE: begin
               if (start && cfg_en) begin
                  idx_q <= '0;
                  st_q  <= WS_FETCH;
               end
            end
            WS_FETCH: begin
               if (mem_ack) begin
                  desc_q <= {desc_q[DESC_BYTES*8-9:0], mem_rdata};
                  idx_q  <= idx_q + 1'b1;
                  if (idx_q == IW'(DESC_BYTES - 1)) st_q <= WS_CHECK;
               end
            end
            WS_CHECK: begin
               if (!ctl_w[BIT_READY]) begin
                  st_q <= WS_IDLE;
               end else begin
                  evt_babt <= clip_hit;
                  eff_q    <= clip_len;
                  boff_q   <= '0;
                  st_q     <= (clip_len == '0) ? WS_WBACK : WS_DATA;
               end
            end
            WS_DATA: begin
               if (mem_ack) begin
                  out_valid <= 1'b1;
                  out_data  <= mem_rdata;
                  cnt_q     <= cnt_q + 1'b1;
                  boff_q    <= boff_q + 1'b1;
                  if (boff_q == eff_q - LW'(1)) st_q <= WS_WBACK;
               end
            end
            WS_WBACK: begin
               if (mem_ack) begin
                  evt_txb <= 1'b1;
                  if (ctl_w[BIT_FINAL]) begin
                     evt_txf <= 1'b1;
                     out_eof <= 1'b1;
                     cnt_q   <= '0;
                  end
                  ptr_q <= ctl_w[BIT_WRAP] ? base_q : ptr_q + AW'(DESC_BYTES);
                  idx_q <= '0;
                  st_q  <= WS_FETCH;
               end
            end
            default: st_q <= WS_IDLE;
         endcase
         if (base_wr) ptr_q <= base_nxt;
      end
   end

   assign walk_idle = (st_q == WS_IDLE);
   assign frame_cnt = cnt_q;
   assign desc_ptr  = ptr_q;
endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine #(
   parameter int AW        = 32,
   parameter int LW        = 16,
   parameter int MAX_FRAME = 2032,
   parameter int ALIGN     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_en,
   input  logic          base_wr,
   input  logic [AW-1:0] base_wdata,
   input  logic          start,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic          mem_ack,
   input  logic [7:0]    mem_rdata,
   output logic          out_valid,
   output logic [7:0]    out_data,
   output logic          out_eof,
   output logic          evt_txb,
   output logic          evt_txf,
   output logic          evt_babt
);
   localparam int CW = $clog2(MAX_FRAME + 1);

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("AW must lie in 8..32");
      end
      if (LW < CW || LW > 16) begin : g_bad_lw
         $error("LW must cover MAX_FRAME and fit the 16-bit count field");
      end
      if (MAX_FRAME < 1) begin : g_bad_max
         $error("MAX_FRAME must be positive");
      end
      if (ALIGN < 0 || ALIGN > 3) begin : g_bad_align
         $error("ALIGN must lie in 0..3");
      end
   endgenerate

   logic [AW-1:0] base_q;
   logic [AW-1:0] base_nxt;
   logic          walk_idle;
   logic [CW-1:0] frame_cnt;
   logic [AW-1:0] desc_ptr;

   tdr_base_reg #(.AW(AW), .ALIGN(ALIGN)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (base_wr),
      .wdata    (base_wdata),
      .base_q   (base_q),
      .base_nxt (base_nxt)
   );

   tdr_walker #(.AW(AW), .LW(LW), .CW(CW), .MAX_FRAME(MAX_FRAME)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_en    (cfg_en),
      .start     (start),
      .base_wr   (base_wr),
      .base_nxt  (base_nxt),
      .base_q    (base_q),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_eof   (out_eof),
      .evt_txb   (evt_txb),
      .evt_txf   (evt_txf),
      .evt_babt  (evt_babt),
      .walk_idle (walk_idle),
      .frame_cnt (frame_cnt),
      .desc_ptr  (desc_ptr)
   );
endmodule

// File: rtl/tdr_checker.sv
module tdr_checker #(
   parameter int AW        = 32,
   parameter int CW        = 11,
   parameter int MAX_FRAME = 2032,
   parameter int ALIGN     = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_en,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic [7:0]    mem_wdata,
   input logic          out_valid,
   input logic          out_eof,
   input logic          evt_txb,
   input logic          walk_idle,
   input logic [CW-1:0] frame_cnt,
   input logic [AW-1:0] desc_ptr
);
   localparam logic [AW-1:0] LOW_MASK = AW'((1 << ALIGN) - 1);

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      walk_idle |=> !out_valid);

   assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_idle && !cfg_en) |=> !mem_req);

   assert_eof_with_txb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> evt_txb);

   assert_frame_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(frame_cnt) <= 32'(MAX_FRAME));

   assert_wb_clears_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !mem_wdata[7]);

   assert_ptr_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_ptr & LOW_MASK) == '0);
endmodule

bind txd_ring_engine tdr_checker #(
   .AW(AW), .CW(CW), .MAX_FRAME(MAX_FRAME), .ALIGN(ALIGN)
) u_tdr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_en    (cfg_en),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .out_valid (out_valid),
   .out_eof   (out_eof),
   .evt_txb   (evt_txb),
   .walk_idle (walk_idle),
   .frame_cnt (frame_cnt),
   .desc_ptr  (desc_ptr)
);

// File: tb/tb_txd_ring_engine.sv
module tb_txd_ring_engine;
   localparam int AW   = 32;
   localparam int RB   = 32'h100;
   localparam int BUFA = 32'h200;
   localparam int BUFB = 32'hA00;

   typedef struct packed {
      logic [15:0] fa, la, fb, lb, eb;
      logic [3:0]  txb, txf, babt;
   } row_t;

   // rows: ctl A, len A, ctl B, len B, expected bytes, txb, txf, babt
   localparam row_t VEC [6] = '{
      '{16'h8800, 16'd5,    16'h0000, 16'd0,   16'd5,    4'd1, 4'd1, 4'd0},
      '{16'h8000, 16'd3,    16'h8800, 16'd4,   16'd7,    4'd2, 4'd1, 4'd0},
      '{16'h8800, 16'd2,    16'h8800, 16'd3,   16'd5,    4'd2, 4'd2, 4'd0},
      '{16'h8800, 16'd0,    16'h0000, 16'd0,   16'd0,    4'd1, 4'd1, 4'd0},
      '{16'h8000, 16'd1500, 16'h8800, 16'd600, 16'd2032, 4'd2, 4'd1, 4'd1},
      '{16'h8800, 16'd2032, 16'h0000, 16'd0,   16'd2032, 4'd1, 4'd1, 4'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b0;
   logic          base_wr = 1'b0;
   logic [AW-1:0] base_wdata = '0;
   logic          start = 1'b0;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata, mem_rdata;
   logic          out_valid, out_eof, evt_txb, evt_txf, evt_babt;
   logic [7:0]    out_data;

   always #2.5 clk = ~clk;

   txd_ring_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .base_wr(base_wr),
      .base_wdata(base_wdata), .start(start), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
      .out_data(out_data), .out_eof(out_eof), .evt_txb(evt_txb),
      .evt_txf(evt_txf), .evt_babt(evt_babt)
   );

   logic [7:0] mem [0:4095];
   logic       ack_q = 1'b0;
   logic [7:0] rd_q = '0;
   assign mem_ack   = ack_q;
   assign mem_rdata = rd_q;

   always @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
      end else if (mem_req && !ack_q) begin
         ack_q <= 1'b1;
         rd_q  <= mem[mem_addr[11:0]];
         if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      end else begin
         ack_q <= 1'b0;
      end
   end

   int         n_chk = 0, n_bad = 0;
   int         nb = 0, n_txb = 0, n_txf = 0, n_eof = 0, n_babt = 0;
   logic       saw_req = 1'b0;
   logic [AW-1:0] first_addr = '0;
   logic [7:0] got [0:4095];
   logic       done = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            got[nb[11:0]] = out_data;
            nb = nb + 1;
         end
         n_txb  = n_txb  + int'(evt_txb);
         n_txf  = n_txf  + int'(evt_txf);
         n_eof  = n_eof  + int'(out_eof);
         n_babt = n_babt + int'(evt_babt);
         if (mem_req && !saw_req) begin
            saw_req    = 1'b1;
            first_addr = mem_addr;
         end
      end
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13) ^ (a >> 5));
   endfunction

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr_counts();
      nb = 0; n_txb = 0; n_txf = 0; n_eof = 0; n_babt = 0; saw_req = 1'b0;
   endtask

   task automatic put_desc(input int a, input logic [15:0] ctl,
                           input logic [15:0] len, input logic [31:0] ba);
      mem[a[11:0]]       <= ctl[15:8];
      mem[12'(a + 1)]    <= ctl[7:0];
      mem[12'(a + 2)]    <= len[15:8];
      mem[12'(a + 3)]    <= len[7:0];
      mem[12'(a + 4)]    <= ba[31:24];
      mem[12'(a + 5)]    <= ba[23:16];
      mem[12'(a + 6)]    <= ba[15:8];
      mem[12'(a + 7)]    <= ba[7:0];
   endtask

   task automatic wr_base(input logic [AW-1:0] v);
      @(negedge clk); base_wr = 1'b1; base_wdata = v;
      @(negedge clk); base_wr = 1'b0;
   endtask

   task automatic kick();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      for (int a = 0; a < 4096; a++) mem[a] <= pat(a);
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset
      chk(!mem_req && !out_valid && !out_eof, "R1 idle outputs", int'(mem_req), 0);
      chk(!evt_txb && !evt_txf && !evt_babt, "R1 events low", int'(evt_txb), 0);

      // R3: start with enable low does nothing
      put_desc(RB, 16'h8800, 16'd3, BUFA);
      put_desc(RB + 8, 16'h0000, 16'd0, BUFB);
      wr_base(RB);
      clr_counts();
      kick();
      repeat (100) @(posedge clk);
      @(negedge clk);
      chk(!saw_req, "R3 no memory request while disabled", int'(saw_req), 0);
      chk(nb == 0, "R3 no bytes while disabled", nb, 0);
      chk(mem[RB] == 8'h88, "R3 descriptor untouched", int'(mem[RB]), 8'h88);

      cfg_en = 1'b1;
      for (int r = 0; r < 6; r++) begin
         row_t v;
         int   ea, ok_data;
         v = VEC[r];
         put_desc(RB, v.fa, v.la, BUFA);
         put_desc(RB + 8, v.fb, v.lb, BUFB);
         put_desc(RB + 16, 16'h0000, 16'd0, 0);
         wr_base(RB + 1);          // R9: low bits dropped
         clr_counts();
         kick();
         repeat (2 * (int'(v.la) + int'(v.lb)) + 300) @(posedge clk);
         @(negedge clk);
         chk(first_addr == AW'(RB), "R9 fetch from aligned base", int'(first_addr), RB);
         chk(nb == int'(v.eb), "R4/R6 frame byte count", nb, int'(v.eb));
         ea = (int'(v.la) < int'(v.eb)) ? int'(v.la) : int'(v.eb);
         ok_data = 1;
         for (int i = 0; i < int'(v.eb) && i < nb; i++) begin
            logic [7:0] e;
            e = (i < ea) ? pat(BUFA + i) : pat(BUFB + i - ea);
            if (got[i] !== e) ok_data = 0;
         end
         chk(ok_data == 1, "R4 frame byte contents in order", ok_data, 1);
         chk(n_txb == int'(v.txb), "R7 buffer events", n_txb, int'(v.txb));
         chk(n_txf == int'(v.txf), "R5 frame events", n_txf, int'(v.txf));
         chk(n_eof == int'(v.txf), "R5 end-of-frame pulses", n_eof, int'(v.txf));
         chk(n_babt == int'(v.babt), "R6 ceiling events", n_babt, int'(v.babt));
         chk(mem[RB] == {1'b0, v.fa[14:8]}, "R7 writeback of slot 0",
             int'(mem[RB]), int'({1'b0, v.fa[14:8]}));
         if (v.fb[15])
            chk(mem[RB + 8] == {1'b0, v.fb[14:8]}, "R8 advance by 8 and writeback",
                int'(mem[RB + 8]), int'({1'b0, v.fb[14:8]}));
         else
            chk(mem[RB + 8] == v.fb[15:8], "R2 stop on not-ready slot",
                int'(mem[RB + 8]), int'(v.fb[15:8]));
      end

      // R8: wrap returns to base, slot 1 is not touched
      put_desc(RB, 16'hA800, 16'd2, BUFA);
      put_desc(RB + 8, 16'h8800, 16'd9, BUFB);
      wr_base(RB);
      clr_counts();
      kick();
      repeat (300) @(posedge clk);
      @(negedge clk);
      chk(nb == 2, "R8 wrap frame bytes", nb, 2);
      chk(n_txb == 1, "R8 one descriptor before wrap stop", n_txb, 1);
      chk(mem[RB + 8] == 8'h88, "R8 slot after wrap left ready", int'(mem[RB + 8]), 8'h88);
      chk(mem[RB] == 8'h28, "R7 wrap/final bits kept on writeback", int'(mem[RB]), 8'h28);

      // R2: resume on the slot where the walk stopped (the base after wrap)
      put_desc(RB, 16'hA800, 16'd4, BUFB);
      clr_counts();
      kick();
      repeat (300) @(posedge clk);
      @(negedge clk);
      chk(first_addr == AW'(RB), "R2 resume at stopped slot", int'(first_addr), RB);
      chk(nb == 4 && got[0] == pat(BUFB), "R2 resumed frame bytes", nb, 4);
      chk(n_eof == 1, "R5 resumed frame closed", n_eof, 1);

      done = 1'b1;
      report();
   end
endmodule